// File: doc/BRIEF.md
# Cartridge Program Bank and Save-RAM Guard

This block sits on an 8-bit CPU bus with a 16-bit address. It watches writes into a 16-byte control window at `$7EF0`-`$7EFF`. It drives the upper address bits of an external program ROM and gates access to 5 KiB of internal save RAM. The CPU reaches ROM through four 8 KiB windows between `$8000` and `$FFFF`. Three of these windows can be switched by writing a bank number into the window. The top window always shows the last bank of the ROM.

The save RAM has three regions. Each region has its own guard register, and a region opens only when its guard register holds its own key byte. While a region is closed, the block drops writes to it and flags reads with an open-bus marker, so the data path can float the bus.

All outputs except the stored registers are combinational functions of the current address and strobe. A register write takes effect on the rising clock edge that samples the strobe.

Top module: `prg_bank_guard`

## Requirements
- R1: After `rst_ni` is low, all three switchable windows select bank 0 and all three save-RAM regions are closed.
- R2: A write to `$7EFA`, `$7EFB` or `$7EFC` stores bits [7:2] of the data byte as the bank for `$8000`-`$9FFF`, `$A000`-`$BFFF` or `$C000`-`$DFFF` respectively. Data bits [1:0] are discarded. The new bank is visible from the clock edge that samples the write.
- R3: Addresses `$E000`-`$FFFF` always select bank `PRG_BANKS-1`, which is 31 by default, whatever has been written.
- R4: `rom_cs_o` is 1 exactly when address bit 15 is 1. `prg_bank_o` is 0 whenever `rom_cs_o` is 0.
- R5: Writing `$CA` to `$7EF7` opens `$6000`-`$67FF`. Writing `$69` to `$7EF8` opens `$6800`-`$6FFF`. Writing `$84` to `$7EF9` opens `$7000`-`$73FF`. Each guard write affects only its own region.
- R6: Writing any other byte to a guard register closes that region, including a byte that is the key of a different region.
- R7: For an access inside an open region, `ram_cs_o`=1, `open_bus_o`=0, `ram_addr_o` = address minus `$6000` (0..`$13FF`), and `ram_we_o` follows `cpu_we_i`.
- R8: For an access inside a closed region, `ram_cs_o`=0, `ram_we_o`=0 and `open_bus_o`=1.
- R9: Addresses below `$6000` and from `$7400` to `$7FFF`, including the control window, give `ram_cs_o`=0, `ram_we_o`=0 and `open_bus_o`=0.
- R10: Writes to window offsets other than 7 through C, and writes whose address differs from `$7EFx` in any upper bit, leave the bank selections and the region states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock; register writes are taken on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| prg_bank_o | output | BANK_W (6) | Program-ROM bank for the current address |
| rom_cs_o | output | 1 | Program-ROM select |
| ram_cs_o | output | 1 | Save-RAM select, set only for open regions |
| ram_addr_o | output | 13 | Save-RAM address |
| ram_we_o | output | 1 | Save-RAM write enable |
| open_bus_o | output | 1 | Access to a closed region; the read data must float |

## Verification
The assertions assume that the address, data and strobe are never unknown after reset. They also assume that an address held for a full cycle without a write into the bank offsets leaves the bank output unchanged. In other words, the inputs only change between edges, and a write is a single strobe pulse over one rising edge. The bench drives every input on the falling edge and holds a write strobe across exactly one rising edge, so each write lands once. It samples outputs shortly after the falling edge, while the address is steady.

// File: rtl/prg_guard_pkg.sv
package prg_guard_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned PAGE_W    = 13;                    // 8 KiB ROM window
  localparam int unsigned WIN_W     = ADDR_W - 1 - PAGE_W;   // window index bits
  localparam int unsigned RAM_AW    = 13;
  localparam int unsigned N_SLOTS   = 3;
  localparam int unsigned N_REGIONS = 3;
  localparam logic [ADDR_W-1:0] REG_BASE = 16'h7EF0;
  localparam logic [3:0] SLOT_OFS0 = 4'hA;
  localparam logic [3:0] LOCK_OFS0 = 4'h7;
  localparam logic [ADDR_W-1:0] RAM_BASE = 16'h6000;

  function automatic logic [DATA_W-1:0] unlock_key(input int idx);
    case (idx)
      0:       return 8'hCA;
      1:       return 8'h69;
      default: return 8'h84;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] region_lo(input int idx);
    case (idx)
      0:       return 16'h6000;
      1:       return 16'h6800;
      default: return 16'h7000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] region_hi(input int idx);
    case (idx)
      0:       return 16'h67FF;
      1:       return 16'h6FFF;
      default: return 16'h73FF;
    endcase
  endfunction
endpackage

// File: rtl/prg_guard_win_dec.sv
module prg_guard_win_dec
  import prg_guard_pkg::*;
#(
  parameter int unsigned NSLOT = N_SLOTS,
  parameter int unsigned NREG  = N_REGIONS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [NSLOT-1:0]  slot_wr_o,
  output logic [NREG-1:0]   lock_wr_o
);
  logic in_win;
  assign in_win = (addr_i[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4]);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_wr_o[s] = we_i & in_win & (addr_i[3:0] == SLOT_OFS0 + 4'(s));
  end

  for (genvar r = 0; r < NREG; r++) begin : g_lock
    assign lock_wr_o[r] = we_i & in_win & (addr_i[3:0] == LOCK_OFS0 + 4'(r));
  end
endmodule

// File: rtl/prg_guard_banks.sv
module prg_guard_banks
  import prg_guard_pkg::*;
#(
  parameter int unsigned NSLOT     = N_SLOTS,
  parameter int unsigned BANK_W    = 6,
  parameter int unsigned PRG_BANKS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSLOT-1:0]  slot_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_cs_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);

  logic [BANK_W-1:0] bank_q [NSLOT];
  logic [WIN_W-1:0]  win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) bank_q[s] <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++)
        if (slot_wr_i[s]) bank_q[s] <= data_i[DATA_W-1 -: BANK_W];
    end
  end

  assign win      = addr_i[ADDR_W-2 -: WIN_W];
  assign rom_cs_o = addr_i[ADDR_W-1];

  always_comb begin
    bank_o = '0;
    if (rom_cs_o) begin
      bank_o = LAST_BANK;  // windows beyond the switchable ones stay fixed
      for (int s = 0; s < NSLOT; s++)
        if (win == WIN_W'(s)) bank_o = bank_q[s];
    end
  end
endmodule

// File: rtl/prg_guard_ram.sv
module prg_guard_ram
  import prg_guard_pkg::*;
#(
  parameter int unsigned NREG = N_REGIONS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREG-1:0]   lock_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              open_bus_o
);
  logic [NREG-1:0] open_q;
  logic [NREG-1:0] hit;
  logic [ADDR_W-1:0] rel;

  // one flag per region: key compare happens at write time only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++)
        if (lock_wr_i[r]) open_q[r] <= (data_i == unlock_key(r));
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign hit[r] = (addr_i >= region_lo(r)) && (addr_i <= region_hi(r));
  end

  assign rel        = addr_i - RAM_BASE;
  assign ram_addr_o = rel[RAM_AW-1:0];
  assign ram_cs_o   = |(hit & open_q);
  assign open_bus_o = |(hit & ~open_q);
  assign ram_we_o   = we_i & ram_cs_o;
endmodule

// File: rtl/prg_bank_guard.sv
module prg_bank_guard
  import prg_guard_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned BANK_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  output logic [BANK_W-1:0] prg_bank_o,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic [12:0]       ram_addr_o,
  output logic              ram_we_o,
  output logic              open_bus_o
);
  logic [N_SLOTS-1:0]   slot_wr;
  logic [N_REGIONS-1:0] lock_wr;

  prg_guard_win_dec #(.NSLOT(N_SLOTS), .NREG(N_REGIONS)) u_dec (
    .addr_i    (cpu_addr_i),
    .we_i      (cpu_we_i),
    .slot_wr_o (slot_wr),
    .lock_wr_o (lock_wr)
  );

  prg_guard_banks #(.NSLOT(N_SLOTS), .BANK_W(BANK_W), .PRG_BANKS(PRG_BANKS)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_wr_i (slot_wr),
    .data_i    (cpu_data_i),
    .addr_i    (cpu_addr_i),
    .rom_cs_o  (rom_cs_o),
    .bank_o    (prg_bank_o)
  );

  prg_guard_ram #(.NREG(N_REGIONS)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_wr_i  (lock_wr),
    .data_i     (cpu_data_i),
    .addr_i     (cpu_addr_i),
    .we_i       (cpu_we_i),
    .ram_cs_o   (ram_cs_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .open_bus_o (open_bus_o)
  );
endmodule

// File: rtl/prg_guard_chk.sv
module prg_guard_chk #(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned BANK_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic [7:0]        cpu_data_i,
  input logic              cpu_we_i,
  input logic [BANK_W-1:0] prg_bank_o,
  input logic              rom_cs_o,
  input logic              ram_cs_o,
  input logic [12:0]       ram_addr_o,
  input logic              ram_we_o,
  input logic              open_bus_o
);
  logic in_r0, in_ram, bank_wr;
  assign in_r0   = (cpu_addr_i[15:11] == 5'b01100);
  assign in_ram  = (cpu_addr_i >= 16'h6000) && (cpu_addr_i <= 16'h73FF);
  assign bank_wr = cpu_we_i && (cpu_addr_i >= 16'h7EFA) && (cpu_addr_i <= 16'h7EFC);

  p_fixed_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b111) |-> (prg_bank_o == BANK_W'(PRG_BANKS - 1)));

  p_rom_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o == cpu_addr_i[15]) && (rom_cs_o || prg_bank_o == '0));

  p_open_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i == 16'h7EF7 && cpu_data_i == 8'hCA) |=> (!in_r0 || ram_cs_o));

  p_close_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i == 16'h7EF7 && cpu_data_i != 8'hCA) |=> (!in_r0 || !ram_cs_o));

  p_cs_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o |-> in_ram);

  p_we_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_cs_o && cpu_we_i && !open_bus_o));

  p_no_ram_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ram |-> (!ram_cs_o && !ram_we_o && !open_bus_o));

  p_bank_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bank_wr && !cpu_we_i) |=> ($stable(cpu_addr_i) -> $stable(prg_bank_o)));
endmodule

bind prg_bank_guard prg_guard_chk #(.PRG_BANKS(PRG_BANKS), .BANK_W(BANK_W)) chk_i (.*);

// File: tb/prg_bank_guard_tb_top.sv
`timescale 1ns/1ps
module prg_bank_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = 16'h0000;
  logic [7:0]  cpu_data_i = 8'h00;
  logic        cpu_we_i = 1'b0;
  logic [5:0]  prg_bank_o;
  logic        rom_cs_o, ram_cs_o, ram_we_o, open_bus_o;
  logic [12:0] ram_addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk_i = ~clk_i;

  prg_bank_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_data_i(cpu_data_i),
    .cpu_we_i(cpu_we_i), .prg_bank_o(prg_bank_o), .rom_cs_o(rom_cs_o), .ram_cs_o(ram_cs_o),
    .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .open_bus_o(open_bus_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr_i, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_we_i = 1'b1;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_we_i = 1'b0;
    #1;
  endtask

  task automatic bank_is(input string req, input logic [15:0] a, input logic [5:0] exp);
    look(a);
    check(req, {31'd0, rom_cs_o}, 32'd1);
    check(req, {26'd0, prg_bank_o}, {26'd0, exp});
  endtask

  // cs, open flag expectation for a region address
  task automatic ram_is(input string req, input logic [15:0] a, input bit open);
    look(a);
    check(req, {31'd0, ram_cs_o}, {31'd0, open});
    check(req, {31'd0, open_bus_o}, {31'd0, ~open});
    if (open) check(req, {19'd0, ram_addr_o}, {16'd0, a} - 32'h6000);
  endtask

  task automatic t_reset;
    bank_is("R1", 16'h8000, 6'd0);
    bank_is("R1", 16'hA123, 6'd0);
    bank_is("R1", 16'hDFFF, 6'd0);
    ram_is("R1", 16'h6000, 0);
    ram_is("R1", 16'h6800, 0);
    ram_is("R1", 16'h7000, 0);
  endtask

  task automatic t_banks;
    wr(16'h7EFA, 8'h15);
    wr(16'h7EFB, 8'hFF);
    wr(16'h7EFC, 8'h83);
    bank_is("R2", 16'h8000, 6'd5);
    bank_is("R2", 16'hBFFF, 6'd63);
    bank_is("R2", 16'hC000, 6'd32);
    wr(16'h7EFA, 8'h16);
    bank_is("R2 low bits", 16'h9FFF, 6'd5);
    wr(16'h7EFA, 8'h04);
    bank_is("R2", 16'h8000, 6'd1);
  endtask

  task automatic t_fixed;
    bank_is("R3", 16'hE000, 6'd31);
    bank_is("R3", 16'hFFFF, 6'd31);
    wr(16'h7EFD, 8'h00);
    bank_is("R3", 16'hF000, 6'd31);
  endtask

  task automatic t_rom_cs;
    look(16'h7FFF);
    check("R4", {31'd0, rom_cs_o}, 32'd0);
    check("R4", {26'd0, prg_bank_o}, 32'd0);
    look(16'h0000);
    check("R4", {31'd0, rom_cs_o}, 32'd0);
    check("R4", {26'd0, prg_bank_o}, 32'd0);
  endtask

  task automatic t_unlock;
    wr(16'h7EF7, 8'hCA);
    ram_is("R5", 16'h6000, 1);
    ram_is("R5", 16'h67FF, 1);
    ram_is("R5", 16'h6800, 0);
    ram_is("R5", 16'h7000, 0);
    wr(16'h7EF8, 8'h69);
    wr(16'h7EF9, 8'h84);
    ram_is("R5", 16'h6FFF, 1);
    ram_is("R5", 16'h7000, 1);
    ram_is("R7", 16'h73FF, 1);
  endtask

  task automatic t_relock;
    wr(16'h7EF7, 8'h84);
    ram_is("R6", 16'h6100, 0);
    ram_is("R6", 16'h6900, 1);
    wr(16'h7EF8, 8'hCA);
    ram_is("R6", 16'h6900, 0);
    ram_is("R6", 16'h7100, 1);
    wr(16'h7EF7, 8'hCA);
    ram_is("R6", 16'h6100, 1);
  endtask

  task automatic t_write_en;
    @(negedge clk_i);
    cpu_addr_i = 16'h6010; cpu_data_i = 8'h55; cpu_we_i = 1'b1;
    #1;
    check("R7", {31'd0, ram_we_o}, 32'd1);
    check("R7", {31'd0, ram_cs_o}, 32'd1);
    @(negedge clk_i);
    cpu_addr_i = 16'h6810;
    #1;
    check("R8", {31'd0, ram_we_o}, 32'd0);
    check("R8", {31'd0, open_bus_o}, 32'd1);
    @(negedge clk_i);
    cpu_we_i = 1'b0;
    #1;
    check("R7", {31'd0, ram_we_o}, 32'd0);
  endtask

  task automatic t_holes;
    logic [15:0] hole [5] = '{16'h5FFF, 16'h7400, 16'h7EEF, 16'h7EF0, 16'h7FFF};
    for (int i = 0; i < 5; i++) begin
      look(hole[i]);
      check("R9", {29'd0, ram_cs_o, open_bus_o, ram_we_o}, 32'd0);
    end
    @(negedge clk_i);
    cpu_addr_i = 16'h7EFF; cpu_data_i = 8'h00; cpu_we_i = 1'b1;
    #1;
    check("R9 we", {29'd0, ram_cs_o, open_bus_o, ram_we_o}, 32'd0);
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic t_ignore;
    logic [15:0] junk [8] = '{16'h7EF0, 16'h7EF3, 16'h7EF6, 16'h7EFE,
                              16'hFEFA, 16'h3EFB, 16'h7FFC, 16'h7AF7};
    for (int i = 0; i < 8; i++) wr(junk[i], 8'hFC);
    bank_is("R10", 16'h8000, 6'd1);
    bank_is("R10", 16'hA000, 6'd63);
    bank_is("R10", 16'hC000, 6'd32);
    ram_is("R10", 16'h6000, 1);
    ram_is("R10", 16'h6800, 0);
    ram_is("R10", 16'h7000, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_banks();
    t_fixed();
    t_rom_cs();
    t_unlock();
    t_relock();
    t_write_en();
    t_holes();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule